// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Line-Drained Status

This block serialises characters for an asynchronous serial line. A CPU-side write places one character into a holding register. When the transmitter is enabled, that character moves into a shift register and goes out on `txd`. Each frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then 1, 1.5 or 2 high stop bits. The line rests high between characters.

The bit rate comes from an external tick enable, `tick_in`. A divide selection sets how many ticks make up one bit cell: 1, 16, 32 or 64. All framing changes happen on bit-cell boundaries. A break request forces the line low. It takes effect, and is released, only at a boundary, and framing continues underneath it.

The `all_sent` output tells software when the transmitter can be switched off safely. It is high only when nothing is waiting and the final stop bit has fully left the pin. A registered request-to-send output is also provided.

The controller is a state machine with five named states:
- ST_IDLE: the line is high.
- ST_START: the start bit.
- ST_DATA: the data bits.
- ST_PARITY: the parity bit.
- ST_STOP: the stop time.

Its transitions are:
- load: ST_IDLE to ST_START, at a cell boundary when enabled with a character waiting.
- first_data: ST_START to ST_DATA, at the next boundary.
- to_parity or to_stop: out of ST_DATA after the last data bit, depending on whether parity is on.
- parity_done: ST_PARITY to ST_STOP.
- chain: ST_STOP to ST_START, when stop time ends with a character waiting and the transmitter enabled.
- drain: ST_STOP to ST_IDLE, otherwise.

Top module: `async_tx`

## Requirements
- R1: After reset, `txd`=1, `all_sent`=1, `hold_empty`=1 and `rts_out`=0. The idle line is high.
- R2: A frame starts with one low start bit, followed by data bits LSB first. The count is set by `len_sel`: 00=5, 01=7, 10=6, 11=8 bits. Data bits above the chosen length are not sent.
- R3: With `par_en`=1, a parity bit follows the data bits. `par_even`=1 makes the total count of ones (data plus parity) even, and `par_even`=0 makes it odd. Unsent bits do not count.
- R4: `stop_sel` sets the stop time in ticks, where M is the divide ratio: 01 gives M, 10 gives M+M/2, 11 gives 2M, and 00 behaves as 01. From the start-bit edge to `all_sent` rising, the frame lasts (1+bits+parity)·M + stop ticks.
- R5: `div_sel` sets M: 00=1, 01=16, 10=32, 11=64. One bit cell lasts M `tick_in` pulses. While `tick_in` is low, `txd` does not change.
- R6: `all_sent` is high only in ST_IDLE with an empty holding register. It goes low on the cycle after a write and rises in the cycle the last stop tick ends.
- R7: While `tx_en`=0, no character starts. A written character waits in the holding register, and it is sent once `tx_en` is set.
- R8: Clearing `tx_en` during a frame lets that frame finish. No further character starts afterwards.
- R9: While break is in force, `txd`=0. A change of `brk_req` takes effect only at the next bit-cell boundary. The frame timing underneath is unchanged.
- R10: If a character is waiting when the stop time ends, its start bit follows with no idle cell.
- R11: `rts_out` equals `rts_req` delayed by one clock.
- R12: `hold_empty` goes low on the cycle after a write. It goes high when the character moves to the shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_in | input | 1 | Bit-clock enable, M pulses per bit |
| tx_en | input | 1 | Transmit enable |
| brk_req | input | 1 | Break request |
| rts_req | input | 1 | Request-to-send control |
| len_sel | input | 2 | Character length code |
| stop_sel | input | 2 | Stop length code |
| par_en | input | 1 | Parity enable |
| par_even | input | 1 | 1 = even parity, 0 = odd |
| div_sel | input | 2 | Ticks-per-bit code |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to write |
| txd | output | 1 | Serial output |
| hold_empty | output | 1 | Holding register is free |
| all_sent | output | 1 | Line fully drained |
| rts_out | output | 1 | Registered request-to-send |

## Verification
The bench builds the block with its default parameters: an 8-bit maximum character and a 6-bit sub-cell counter. This brings every divide ratio within reach, up to 64 ticks per bit, so every length, parity and stop combination is exercised. That includes the x1 case, where half a stop cell rounds down to nothing. Because `tick_in` is fixed high except during one deliberate stall, frame lengths are exact cycle counts. This lets the bench pin the start edge, every bit centre and the `all_sent` rise to single cycles.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_e;

    // character length code to (bits - 1)
    function automatic int len_minus_one(input logic [1:0] code);
        unique case (code)
            2'b00:   return 4;
            2'b01:   return 6;
            2'b10:   return 5;
            default: return 7;
        endcase
    endfunction

endpackage

// File: rtl/async_tx_cell_timer.sv
module async_tx_cell_timer #(
    parameter int SUB_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [1:0]       div_sel,
    input  logic             restart,
    output logic [SUB_W:0]   ratio,
    output logic             cell_end
);
    localparam int CNT_W = SUB_W + 1;

    logic [SUB_W-1:0] sub_q;
    logic [SUB_W-1:0] last;

    always_comb begin
        if (div_sel == 2'b00) ratio = CNT_W'(1);
        else                  ratio = CNT_W'(1) << (32'(div_sel) + 3);
    end

    assign last     = SUB_W'(ratio - CNT_W'(1));
    assign cell_end = tick && (sub_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sub_q <= '0;
        else if (restart)  sub_q <= '0;
        else if (tick)     sub_q <= cell_end ? '0 : sub_q + 1'b1;
    end
endmodule

// File: rtl/async_tx_frame_calc.sv
module async_tx_frame_calc #(
    parameter int DATA_W = 8,
    parameter int SUB_W  = 6,
    parameter int IDX_W  = $clog2(DATA_W),
    parameter int STOP_W = SUB_W + 2
) (
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        len_sel,
    input  logic              par_even,
    input  logic [1:0]        stop_sel,
    input  logic [SUB_W:0]    ratio,
    output logic [IDX_W-1:0]  nbits_m1,
    output logic              par_bit,
    output logic [STOP_W-1:0] stop_last
);
    import async_tx_pkg::*;

    logic [DATA_W-1:0] masked;
    logic [STOP_W-1:0] r;

    assign nbits_m1 = IDX_W'(len_minus_one(len_sel));

    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign masked[i] = data[i] & (IDX_W'(i) <= nbits_m1);
    end

    assign par_bit = par_even ? (^masked) : ~(^masked);
    assign r       = STOP_W'(ratio);

    always_comb begin
        unique case (stop_sel)
            2'b10:   stop_last = r + (r >> 1) - STOP_W'(1);
            2'b11:   stop_last = (r << 1) - STOP_W'(1);
            default: stop_last = r - STOP_W'(1);
        endcase
    end
endmodule

// File: rtl/async_tx.sv
module async_tx #(
    parameter int DATA_W = 8,
    parameter int SUB_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              tx_en,
    input  logic              brk_req,
    input  logic              rts_req,
    input  logic [1:0]        len_sel,
    input  logic [1:0]        stop_sel,
    input  logic              par_en,
    input  logic              par_even,
    input  logic [1:0]        div_sel,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              hold_empty,
    output logic              all_sent,
    output logic              rts_out
);
    import async_tx_pkg::*;

    localparam int IDX_W  = $clog2(DATA_W);
    localparam int STOP_W = SUB_W + 2;

    tx_state_e         state_q, state_d;
    logic [DATA_W-1:0] hold_q, shift_q;
    logic              hold_full_q;
    logic [IDX_W-1:0]  idx_q, nbits_q, nbits_c;
    logic              par_q, par_on_q, par_c;
    logic [STOP_W-1:0] stop_last_q, stop_last_c, stop_cnt_q;
    logic              brk_line_q, rts_q;
    logic [SUB_W:0]    ratio;
    logic              cell_end, stop_done, take, line;

    async_tx_cell_timer #(.SUB_W(SUB_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_in),
        .div_sel  (div_sel),
        .restart  (stop_done),
        .ratio    (ratio),
        .cell_end (cell_end)
    );

    async_tx_frame_calc #(
        .DATA_W (DATA_W),
        .SUB_W  (SUB_W),
        .IDX_W  (IDX_W),
        .STOP_W (STOP_W)
    ) u_calc (
        .data      (hold_q),
        .len_sel   (len_sel),
        .par_even  (par_even),
        .stop_sel  (stop_sel),
        .ratio     (ratio),
        .nbits_m1  (nbits_c),
        .par_bit   (par_c),
        .stop_last (stop_last_c)
    );

    assign stop_done = (state_q == ST_STOP) && tick_in && (stop_cnt_q == stop_last_q);

    // next state and transition naming
    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cell_end && tx_en && hold_full_q) begin   // load
                    state_d = ST_START;
                    take    = 1'b1;
                end
            end
            ST_START: begin
                if (cell_end) state_d = ST_DATA;               // first_data
            end
            ST_DATA: begin
                if (cell_end && idx_q == nbits_q)
                    state_d = par_on_q ? ST_PARITY : ST_STOP;  // to_parity / to_stop
            end
            ST_PARITY: begin
                if (cell_end) state_d = ST_STOP;               // parity_done
            end
            ST_STOP: begin
                if (stop_done) begin
                    if (tx_en && hold_full_q) begin            // chain
                        state_d = ST_START;
                        take    = 1'b1;
                    end else begin                             // drain
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q      <= '0;
            hold_full_q <= 1'b0;
            shift_q     <= '0;
            idx_q       <= '0;
            nbits_q     <= '0;
            par_q       <= 1'b0;
            par_on_q    <= 1'b0;
            stop_last_q <= '0;
            stop_cnt_q  <= '0;
            brk_line_q  <= 1'b0;
            rts_q       <= 1'b0;
        end else begin
            rts_q <= rts_req;
            if (wr_valid) begin
                hold_q      <= wr_data;
                hold_full_q <= 1'b1;
            end else if (take) begin
                hold_full_q <= 1'b0;
            end
            if (take) begin
                shift_q     <= hold_q;
                idx_q       <= '0;
                nbits_q     <= nbits_c;
                par_q       <= par_c;
                par_on_q    <= par_en;
                stop_last_q <= stop_last_c;
            end else if (state_q == ST_DATA && cell_end) begin
                shift_q <= shift_q >> 1;
                idx_q   <= idx_q + 1'b1;
            end
            if (state_q != ST_STOP && state_d == ST_STOP) stop_cnt_q <= '0;
            else if (state_q == ST_STOP && tick_in)       stop_cnt_q <= stop_cnt_q + 1'b1;
            if (cell_end || stop_done) brk_line_q <= brk_req;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_IDLE:   line = 1'b1;
            ST_START:  line = 1'b0;
            ST_DATA:   line = shift_q[0];
            ST_PARITY: line = par_q;
            ST_STOP:   line = 1'b1;
            default:   line = 1'b1;
        endcase
        txd        = brk_line_q ? 1'b0 : line;
        hold_empty = !hold_full_q;
        all_sent   = (state_q == ST_IDLE) && !hold_full_q;
        rts_out    = rts_q;
    end
endmodule

// File: rtl/async_tx_checker.sv
module async_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic tick_in,
    input logic wr_valid,
    input logic rts_req,
    input logic brk_line,
    input logic txd,
    input logic hold_empty,
    input logic all_sent,
    input logic rts_out
);
    p_break_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        brk_line |-> !txd);

    p_drained_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (all_sent && !brk_line) |-> txd);

    p_drained_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        all_sent |-> hold_empty);

    p_write_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !all_sent);

    p_write_fills_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !hold_empty);

    p_no_tick_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_in |=> $stable(txd));

    p_rts_delay_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rts_out == $past(rts_req)));
endmodule

bind async_tx async_tx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_in    (tick_in),
    .wr_valid   (wr_valid),
    .rts_req    (rts_req),
    .brk_line   (brk_line_q),
    .txd        (txd),
    .hold_empty (hold_empty),
    .all_sent   (all_sent),
    .rts_out    (rts_out)
);

// File: tb/async_tx_test.sv
`timescale 1ns/1ps
module async_tx_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_in = 1'b1, tx_en = 1'b0, brk_req = 1'b0, rts_req = 1'b0;
    logic [1:0] len_sel = 2'b11, stop_sel = 2'b01, div_sel = 2'b00;
    logic par_en = 1'b0, par_even = 1'b0, wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic txd, hold_empty, all_sent, rts_out;

    int cyc = 0, k0 = 0, n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    async_tx uut (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .tx_en(tx_en),
        .brk_req(brk_req), .rts_req(rts_req), .len_sel(len_sel),
        .stop_sel(stop_sel), .par_en(par_en), .par_even(par_even),
        .div_sel(div_sel), .wr_valid(wr_valid), .wr_data(wr_data),
        .txd(txd), .hold_empty(hold_empty), .all_sent(all_sent),
        .rts_out(rts_out)
    );

    function automatic int f_len(input logic [1:0] c);
        return (c == 2'b00) ? 5 : (c == 2'b01) ? 7 : (c == 2'b10) ? 6 : 8;
    endfunction
    function automatic int f_div(input logic [1:0] c);
        return (c == 2'b00) ? 1 : (c == 2'b01) ? 16 : (c == 2'b10) ? 32 : 64;
    endfunction
    function automatic int f_stop(input logic [1:0] s, input int m);
        return (s == 2'b10) ? m + m / 2 : (s == 2'b11) ? 2 * m : m;
    endfunction
    function automatic bit f_par(input logic [7:0] d, input int n, input bit even);
        bit x = 1'b0;
        for (int i = 0; i < n; i++) x ^= d[i];
        return even ? x : ~x;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic write_char(input logic [7:0] d);
        wr_data  = d;
        wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic detect_start();
        int t = 0;
        while (txd !== 1'b0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        chk("R2 start bit seen", (t < 5000) ? 1 : 0, 1);
        k0 = cyc;
    endtask

    // mode 0: drains; mode 1: next start follows; mode 2: held char stays
    task automatic check_frame(input logic [7:0] d, input int mode);
        int n = f_len(len_sel);
        int m = f_div(div_sel);
        int p = par_en ? 1 : 0;
        int s = f_stop(stop_sel, m);
        int fl = (1 + n + p) * m + s;
        int bad_idle = 0;
        for (int j = 0; j < n; j++) begin
            wait_to(k0 + (1 + j) * m + m / 2);
            chk($sformatf("R2 data bit %0d", j), int'(txd), int'(d[j]));
        end
        if (p == 1) begin
            wait_to(k0 + (1 + n) * m + m / 2);
            chk("R3 parity bit", int'(txd), int'(f_par(d, n, par_even)));
        end
        wait_to(k0 + (1 + n + p) * m);
        chk("R4 stop level", int'(txd), 1);
        wait_to(k0 + fl - 1);
        chk("R6 all_sent low before last stop tick", int'(all_sent), 0);
        wait_to(k0 + fl);
        if (mode == 0) begin
            chk("R4 R6 all_sent at frame end", int'(all_sent), 1);
            chk("R1 idle line high", int'(txd), 1);
        end else if (mode == 1) begin
            chk("R10 next start immediately", int'(txd), 0);
            k0 = k0 + fl;
        end else begin
            chk("R8 held char kept", int'(hold_empty), 0);
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (txd !== 1'b1) bad_idle++;
            end
            chk("R8 no start after disable", bad_idle, 0);
            chk("R7 all_sent low with held char", int'(all_sent), 0);
        end
    endtask

    task automatic set_cfg(input logic [1:0] l, input logic [1:0] s,
                           input logic pe, input logic ev, input logic [1:0] dv);
        len_sel = l; stop_sel = s; par_en = pe; par_even = ev; div_sel = dv;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int bad_line;
        logic [7:0] a;
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        // R1 reset state
        chk("R1 txd reset", int'(txd), 1);
        chk("R1 all_sent reset", int'(all_sent), 1);
        chk("R1 hold_empty reset", int'(hold_empty), 1);
        chk("R1 rts_out reset", int'(rts_out), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 request-to-send delay
        rts_req = 1'b1;
        @(negedge clk);
        chk("R11 rts follows", int'(rts_out), 1);
        rts_req = 1'b0;
        @(negedge clk);
        chk("R11 rts drops", int'(rts_out), 0);

        // R7 disabled: held char does not go out
        set_cfg(2'b11, 2'b01, 1'b0, 1'b0, 2'b01);
        write_char(8'h81);
        chk("R12 hold_empty after write", int'(hold_empty), 0);
        chk("R6 all_sent after write", int'(all_sent), 0);
        bad_line = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) bad_line++;
        end
        chk("R7 line idle while disabled", bad_line, 0);
        tx_en = 1'b1;
        detect_start();
        chk("R12 hold_empty after load", int'(hold_empty), 1);
        check_frame(8'h81, 0);

        // R5 tick stall holds the line
        set_cfg(2'b11, 2'b01, 1'b0, 1'b0, 2'b01);
        write_char(8'h5A);
        detect_start();
        wait_to(k0 + 3);
        tick_in  = 1'b0;
        bad_line = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (txd !== 1'b0) bad_line++;
        end
        tick_in = 1'b1;
        chk("R5 line held without tick", bad_line, 0);
        k0 = k0 + 40;
        check_frame(8'h5A, 0);

        // R9 break mid-frame
        set_cfg(2'b11, 2'b01, 1'b0, 1'b0, 2'b01);
        write_char(8'hFF);
        detect_start();
        wait_to(k0 + 16);
        brk_req = 1'b1;
        wait_to(k0 + 31);
        chk("R9 break waits for boundary", int'(txd), 1);
        wait_to(k0 + 32);
        chk("R9 break forces low", int'(txd), 0);
        wait_to(k0 + 80);
        chk("R9 break holds low", int'(txd), 0);
        brk_req = 1'b0;
        wait_to(k0 + 95);
        chk("R9 release waits for boundary", int'(txd), 0);
        wait_to(k0 + 96);
        chk("R9 release restores data", int'(txd), 1);
        wait_to(k0 + 159);
        chk("R9 timing kept under break", int'(all_sent), 0);
        wait_to(k0 + 160);
        chk("R9 R4 drained on time", int'(all_sent), 1);

        // R10 back-to-back, x1, 7 bits, odd parity, 2 stops
        set_cfg(2'b01, 2'b11, 1'b1, 1'b0, 2'b00);
        write_char(8'h3C);
        detect_start();
        write_char(8'h6B);
        chk("R12 second char held", int'(hold_empty), 0);
        check_frame(8'h3C, 1);
        check_frame(8'h6B, 0);

        // R8 disable mid-frame with a char waiting
        set_cfg(2'b11, 2'b01, 1'b1, 1'b1, 2'b01);
        write_char(8'h33);
        detect_start();
        write_char(8'hC4);
        tx_en = 1'b0;
        check_frame(8'h33, 2);
        tx_en = 1'b1;
        detect_start();
        check_frame(8'hC4, 0);

        // R3 R4 x1 with 1.5 stop rounds to one tick
        set_cfg(2'b00, 2'b10, 1'b1, 1'b1, 2'b00);
        write_char(8'hE7);
        detect_start();
        check_frame(8'hE7, 0);

        // random frames
        for (int it = 0; it < 30; it++) begin
            set_cfg(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                    1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                    2'($urandom_range(0, 3)));
            a = 8'($urandom);
            rts_req = 1'($urandom_range(0, 1));
            write_char(a);
            chk("R11 rts random", int'(rts_out), int'(rts_req));
            detect_start();
            check_frame(a, 0);
        end

        finish_run();
    end
endmodule